// File: doc/BRIEF.md
# Streaming AES-Round Fingerprint Engine

This engine reduces a stream of 64-byte blocks to a 512-bit digest. Its state is four 128-bit lanes seeded with fixed constants. Each incoming block is not encrypted. It is cut into four 128-bit round keys, one per lane, and every lane takes a single AES round under its own key. Lanes 0 and 2 take forward (cipher) rounds and lanes 1 and 3 take inverse (decipher) rounds. The engine accepts one block on every clock cycle.

When the block flagged as the final one has been taken in, the engine spends two cycles finishing. In each of those cycles every lane takes one more round under a constant key that all lanes share, and each lane keeps its forward or inverse direction. The digest is the lane state after the second finishing round. A one-cycle done pulse marks it.

A producer streams blocks with a valid/last pair and watches `ready_o`. A new digest begins with the first block after reset or after done, or with a `start_i` pulse.

Top module: `aesfp_core`

## Requirements
- R1: While reset is active and after it is released, `ready_o` is 1, `done_o` is 0 and `digest_o` holds the initial constants. Lane j occupies bits [128j+127:128j]. Byte i of a lane occupies bits [8i+7:8i], and byte i is AES row i%4 of column i/4.
- R2: An accepted block updates lane j with one AES round keyed by block bits [128j+127:128j], using the same byte order as R1. A forward round is SubBytes, ShiftRows, MixColumns and then key XOR. An inverse round is InvSubBytes, InvShiftRows, InvMixColumns and then key XOR. Even lanes take forward rounds and odd lanes take inverse rounds. The updated state shows on `digest_o` after the accepting edge.
- R3: The first block accepted after reset or after a done pulse is applied to the initial constants, not to the previous digest.
- R4: A cycle with `ready_o` high and neither `blk_valid_i` nor `start_i` leaves `digest_o` unchanged.
- R5: After the edge that accepts a block with `blk_last_i`, `ready_o` is 0 for two cycles. `done_o` is then 1 for exactly one cycle, together with `ready_o` = 1 and the final digest.
- R6: Blocks presented while `ready_o` is 0 are ignored.
- R7: When `ready_o` is high, `start_i` reloads the initial constants. A block presented in the same cycle as `start_i` is applied to the constants.
- R8: Blocks presented on consecutive cycles are all accepted, one per cycle.
- R9: The first finishing round uses key X0 = 0x06890201_90dc56bf_8b24949f_f6fa8389 and the second uses X1 = 0xed18f99b_ee1043c6_51f4e03c_61b263d1 (bit 127 on the left). Both keys apply to all four lanes, and each lane keeps the direction it has in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart from the initial constants |
| blk_valid_i | input | 1 | Block present |
| blk_last_i | input | 1 | Block is the final one of the stream |
| blk_data_i | input | 512 | Block, split into four lane keys |
| ready_o | output | 1 | Block can be accepted this cycle |
| done_o | output | 1 | Digest complete (one-cycle pulse) |
| digest_o | output | 512 | Lane state, and the digest when done_o is high |

## Verification
Each accepted block changes `digest_o` right after the edge that takes it in. The bench therefore compares the running state at the next falling edge, before it drives the next block. `ready_o` must read low at the first and second falling edges after the last block is taken. `done_o` and the final digest are expected at the third falling edge, and `done_o` must be low again at the fourth. The bench keeps its own forward and inverse round model, which it uses for every expected value. It sweeps stream lengths with back-to-back and gapped delivery, restart pulses, and blocks driven during finishing.

// File: rtl/aesfp_pkg.sv
package aesfp_pkg;
  localparam int unsigned NLANE  = 4;
  localparam int unsigned LANE_W = 128;
  localparam int unsigned BLK_W  = NLANE * LANE_W;

  typedef enum logic [1:0] {PH_ABS, PH_FX0, PH_FX1} phase_e;

  localparam logic [BLK_W-1:0] INIT_ST = {
    128'h7e994948_79a10005_07ad828d_630a240c,
    128'he8a07ce4_5079506b_ae62c7d0_6a770017,
    128'hace78057_f59e125a_15c7b798_338d996e,
    128'hd7983aad_cc82db47_9fa856de_92b52c0d};
  localparam logic [LANE_W-1:0] XKEY0 = 128'h06890201_90dc56bf_8b24949f_f6fa8389;
  localparam logic [LANE_W-1:0] XKEY1 = 128'hed18f99b_ee1043c6_51f4e03c_61b263d1;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // x^254 is the field inverse, and 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq, r;
    sq = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] aff_fwd(input logic [7:0] b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] aff_inv(input logic [7:0] s);
    return rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
  endfunction
endpackage

// File: rtl/aesfp_sbox.sv
module aesfp_sbox #(
  parameter bit INV = 1'b0
) (
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  import aesfp_pkg::*;
  generate
    if (INV) begin : g_inv
      assign byte_o = gf_inv(aff_inv(byte_i));
    end else begin : g_fwd
      assign byte_o = aff_fwd(gf_inv(byte_i));
    end
  endgenerate
endmodule

// File: rtl/aesfp_lane_round.sv
module aesfp_lane_round #(
  parameter bit INV = 1'b0
) (
  input  logic [127:0] st_i,
  input  logic [127:0] key_i,
  output logic [127:0] st_o
);
  import aesfp_pkg::*;
  localparam int unsigned NB = 16;

  logic [7:0] sub_b [NB];
  logic [7:0] shf_b [NB];
  logic [7:0] mix_b [NB];

  for (genvar i = 0; i < NB; i++) begin : g_sub
    aesfp_sbox #(.INV(INV)) u_sbox (.byte_i(st_i[8*i +: 8]), .byte_o(sub_b[i]));
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int SRC_C = INV ? ((c + 4 - r) % 4) : ((c + r) % 4);
      assign shf_b[4*c+r] = sub_b[4*SRC_C+r];
      if (INV) begin : g_imix
        assign mix_b[4*c+r] = gf_mul(shf_b[4*c+r], 8'h0e)
                            ^ gf_mul(shf_b[4*c+((r+1)%4)], 8'h0b)
                            ^ gf_mul(shf_b[4*c+((r+2)%4)], 8'h0d)
                            ^ gf_mul(shf_b[4*c+((r+3)%4)], 8'h09);
      end else begin : g_fmix
        assign mix_b[4*c+r] = gf_mul(shf_b[4*c+r], 8'h02)
                            ^ gf_mul(shf_b[4*c+((r+1)%4)], 8'h03)
                            ^ shf_b[4*c+((r+2)%4)]
                            ^ shf_b[4*c+((r+3)%4)];
      end
      assign st_o[8*(4*c+r) +: 8] = mix_b[4*c+r] ^ key_i[8*(4*c+r) +: 8];
    end
  end
endmodule

// File: rtl/aesfp_core.sv
module aesfp_core
  import aesfp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             blk_valid_i,
  input  logic             blk_last_i,
  input  logic [BLK_W-1:0] blk_data_i,
  output logic             ready_o,
  output logic             done_o,
  output logic [BLK_W-1:0] digest_o
);
  phase_e           phase_q;
  logic [BLK_W-1:0] st_q, rnd_in, rnd_out;
  logic             fresh_q, done_q, accept;

  assign ready_o  = (phase_q == PH_ABS);
  assign accept   = ready_o & blk_valid_i;
  assign done_o   = done_q;
  assign digest_o = st_q;

  // absorbing starts from the constants when fresh or restarted
  assign rnd_in = (ready_o && (fresh_q || start_i)) ? INIT_ST : st_q;

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    logic [LANE_W-1:0] key;
    always_comb begin
      unique case (phase_q)
        PH_FX0:  key = XKEY0;
        PH_FX1:  key = XKEY1;
        default: key = blk_data_i[LANE_W*j +: LANE_W];
      endcase
    end
    aesfp_lane_round #(.INV(j % 2 == 1)) u_round (
      .st_i (rnd_in[LANE_W*j +: LANE_W]),
      .key_i(key),
      .st_o (rnd_out[LANE_W*j +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ABS;
      st_q    <= INIT_ST;
      fresh_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_ABS: begin
          if (accept) begin
            st_q    <= rnd_out;
            fresh_q <= 1'b0;
            if (blk_last_i) phase_q <= PH_FX0;
          end else if (start_i) begin
            st_q    <= INIT_ST;
            fresh_q <= 1'b1;
          end
        end
        PH_FX0: begin
          st_q    <= rnd_out;
          phase_q <= PH_FX1;
        end
        default: begin
          st_q    <= rnd_out;
          phase_q <= PH_ABS;
          done_q  <= 1'b1;
          fresh_q <= 1'b1;
        end
      endcase
    end
  end

  a_r5_ready_low_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && blk_last_i) |=> !ready_o);
  a_r5_done_after_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FX1) |=> (done_o && ready_o));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_fin_second_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FX0) |=> (!ready_o && !done_o));
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !blk_valid_i && !start_i) |=> $stable(digest_o));
  a_r7_restart_loads_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && !blk_valid_i) |=> (digest_o == INIT_ST));
endmodule

// File: tb/tb_aesfp_core.sv
`timescale 1ns/1ps
module tb_aesfp_core;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         blk_valid_i = 1'b0;
  logic         blk_last_i = 1'b0;
  logic [511:0] blk_data_i = '0;
  logic         ready_o, done_o;
  logic [511:0] digest_o;

  aesfp_core dut (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  localparam logic [511:0] T_INIT = {
    128'h7e994948_79a10005_07ad828d_630a240c,
    128'he8a07ce4_5079506b_ae62c7d0_6a770017,
    128'hace78057_f59e125a_15c7b798_338d996e,
    128'hd7983aad_cc82db47_9fa856de_92b52c0d};
  localparam logic [127:0] T_X0 = 128'h06890201_90dc56bf_8b24949f_f6fa8389;
  localparam logic [127:0] T_X1 = 128'hed18f99b_ee1043c6_51f4e03c_61b263d1;

  logic [7:0] sb [256];
  logic [7:0] isb [256];
  logic [511:0] m_st;
  bit m_fresh;
  bit pend;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mulc(input logic [7:0] a, input int n);
    logic [7:0] p = a, acc = 8'h00;
    for (int k = 0; k < 4; k++) begin
      if (n[k]) acc ^= p;
      p = xt(p);
    end
    return acc;
  endfunction

  function automatic logic [127:0] lane_rnd(input logic [127:0] s, input logic [127:0] k, input bit dec);
    logic [7:0] a [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) a[i] = s[8*i +: 8];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        t[4*c+r] = dec ? isb[a[4*((c+4-r)%4)+r]] : sb[a[4*((c+r)%4)+r]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] v;
        if (dec)
          v = mulc(t[4*c+r], 14) ^ mulc(t[4*c+(r+1)%4], 11)
            ^ mulc(t[4*c+(r+2)%4], 13) ^ mulc(t[4*c+(r+3)%4], 9);
        else
          v = xt(t[4*c+r]) ^ xt(t[4*c+(r+1)%4]) ^ t[4*c+(r+1)%4]
            ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
        o[8*(4*c+r) +: 8] = v;
      end
    return o ^ k;
  endfunction

  function automatic logic [511:0] all_rnd(input logic [511:0] s, input logic [511:0] k);
    logic [511:0] o;
    for (int j = 0; j < 4; j++) o[128*j +: 128] = lane_rnd(s[128*j +: 128], k[128*j +: 128], j[0]);
    return o;
  endfunction

  task automatic chk1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b want %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkd(input string req, input logic [511:0] exp);
    total++;
    if (digest_o !== exp) begin
      bad++;
      $display("FAIL %s: got %h want %h", req, digest_o, exp);
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // every step: sample at falling edge, then drive
  task automatic send(input logic [511:0] d, input bit last, input bit with_start);
    @(negedge clk_i);
    if (pend) begin chkd("R2 R8 running state", m_st); pend = 0; end
    chk1("R8 ready during stream", ready_o, 1'b1);
    blk_valid_i = 1'b1; blk_last_i = last; blk_data_i = d; start_i = with_start;
    if (with_start) m_fresh = 1;
    m_st = all_rnd(m_fresh ? T_INIT : m_st, d);
    m_fresh = 0;
    pend = !last;
  endtask

  task automatic idle();
    @(negedge clk_i);
    if (pend) begin chkd("R2 running state", m_st); pend = 0; end
    blk_valid_i = 1'b0; blk_last_i = 1'b0; start_i = 1'b0;
    @(negedge clk_i);
    chkd("R4 idle hold", m_st);
  endtask

  task automatic finish_msg();
    @(negedge clk_i);
    chk1("R5 ready low fin1", ready_o, 1'b0);
    chk1("R5 no done fin1", done_o, 1'b0);
    blk_valid_i = 1'b1; blk_last_i = 1'b1; blk_data_i = rnd512(); start_i = 1'b0;
    @(negedge clk_i);
    chk1("R5 ready low fin2", ready_o, 1'b0);
    chk1("R6 no done fin2", done_o, 1'b0);
    blk_data_i = rnd512();
    @(negedge clk_i);
    m_st = all_rnd(m_st, {4{T_X0}});
    m_st = all_rnd(m_st, {4{T_X1}});
    m_fresh = 1;
    chk1("R5 done pulse", done_o, 1'b1);
    chk1("R5 ready back", ready_o, 1'b1);
    chkd("R9 final digest", m_st);
    blk_valid_i = 1'b0; blk_last_i = 1'b0;
    @(negedge clk_i);
    chk1("R5 done one cycle", done_o, 1'b0);
    chkd("R6 fin input ignored", m_st);
  endtask

  initial begin
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ xt(p);
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]} ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
    for (int i = 0; i < 256; i++) isb[sb[i]] = i[7:0];

    m_st = T_INIT; m_fresh = 1; pend = 0;
    repeat (3) @(negedge clk_i);
    chkd("R1 digest in reset", T_INIT);
    chk1("R1 ready in reset", ready_o, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk1("R1 done low", done_o, 1'b0);
    chkd("R1 digest after reset", T_INIT);

    // first block after reset, then a sweep of lengths and gaps
    for (int n = 1; n <= 6; n++) begin
      for (int b = 0; b < n; b++) begin
        send(rnd512(), b == n - 1, 1'b0);
        if (b == 0 && n > 1) begin
          @(negedge clk_i);
          chkd("R3 first block from constants", m_st); pend = 0;
          blk_valid_i = 1'b0; blk_last_i = 1'b0;
        end else if (n % 2 == 0 && b != n - 1) begin
          idle();
        end
      end
      finish_msg();
    end

    // restart in the middle of a stream
    send(rnd512(), 1'b0, 1'b0);
    @(negedge clk_i);
    chkd("R2 partial", m_st); pend = 0;
    blk_valid_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    m_st = T_INIT; m_fresh = 1;
    chkd("R7 start reloads constants", T_INIT);
    send(rnd512(), 1'b0, 1'b0);
    send(rnd512(), 1'b0, 1'b1);
    @(negedge clk_i);
    chkd("R7 start with block", m_st); pend = 0;
    start_i = 1'b0;
    blk_valid_i = 1'b0;
    send(rnd512(), 1'b1, 1'b0);
    finish_msg();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule